// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block is one programmable logic cell. Two eight-entry truth tables are addressed by the same three low inputs. The fourth input then chooses between the two table outputs, so the cell can realise any Boolean function of four variables. A single storage element can register the result. It has a selectable active clock edge, an optional clock enable and an optional synchronous force to a chosen value.

A parallel 22-bit configuration word sets all of the behaviour. Bits 7:0 hold the first table, called table A. Bits 15:8 hold the second table, called table B. Bits 21:16 hold six control flags. Table A's output is also brought out on its own pin. That pin can serve as a carry-style output next to the main output.

Top module: `clb_cell`

## Requirements
- R1: `c_out` equals table A bit `cfg_word[i]`, where i = `din[2:0]` read as an unsigned number (address 111 selects bit 7, address 000 selects bit 0).
- R2: When control flag `cfg_word[19]` is 1, the cell function is table A at index `din[2:0]` for `din[3]`=0 and table B (`cfg_word[8+i]`) for `din[3]`=1. When the flag is 0, the function is table A at that index and `din[3]` has no effect.
- R3: When `cfg_word[21]` is 0, `q_out` shows the cell function combinationally, in the same cycle the inputs change.
- R4: When `cfg_word[21]` is 1, `q_out` shows the storage element. The element loads the cell function at each active clock edge.
- R5: With `cfg_word[20]`=0 only rising edges of `clk` update the element. With `cfg_word[20]`=1 only falling edges update it.
- R6: With `cfg_word[16]`=1, an active edge where `ce_in` is 0 leaves the element unchanged. With `cfg_word[16]`=0, `ce_in` is ignored.
- R7: With `cfg_word[17]`=1, `sr_in`=1 at an active edge loads the value of `cfg_word[18]` (1 sets, 0 clears), whatever `ce_in` is. With `cfg_word[17]`=0, `sr_in` is ignored.
- R8: `rst`=1 at an active edge clears the element to 0. This has priority over `sr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; the active edge comes from the configuration |
| rst | input | 1 | Synchronous active-high reset of the storage element |
| cfg_word | input | 22 | Configuration: table A, table B, six control flags |
| din | input | 4 | Logic inputs; bits 2:0 address the tables, bit 3 selects between them |
| ce_in | input | 1 | Clock enable, honoured when enabled by configuration |
| sr_in | input | 1 | Synchronous set/reset request, honoured when enabled |
| q_out | output | 1 | Main output: combinational or registered cell function |
| c_out | output | 1 | Direct output of table A |

## Verification
A wrong table address or table choice is visible on `c_out` or, in combinational mode, on `q_out` in the very cycle the inputs settle. Every input combination is swept for several table contents so that no entry goes unseen. A wrong storage value, such as a missed hold, an ignored force, a wrong force polarity or a reaction to the wrong edge, appears on `q_out` right after the first active edge that should have produced another value. For this reason the registered checks sample between the two edges of a clock period, so that edge sensitivity can be told apart.

// File: rtl/clb_pkg.sv
package clb_pkg;

    localparam int unsigned LUT_IN   = 3;
    localparam int unsigned LUT_SIZE = 1 << LUT_IN;
    localparam int unsigned NUM_LUT  = 2;
    localparam int unsigned NUM_CTL  = 6;
    localparam int unsigned CFG_W    = NUM_LUT * LUT_SIZE + NUM_CTL;
    localparam int unsigned DIN_W    = LUT_IN + 1;

    // Control flags, MSB first so bit 0 of the struct is the enable flag.
    typedef struct packed {
        logic reg_out;   // 5: main output from storage element
        logic neg_edge;  // 4: falling-edge clocking
        logic use_mux;   // 3: fourth input chooses between tables
        logic sr_val;    // 2: forced value
        logic sr_en;     // 1: honour set/reset request
        logic ce_en;     // 0: honour clock enable
    } ctl_t;

    typedef struct packed {
        ctl_t                ctl;
        logic [LUT_SIZE-1:0] tab_b;
        logic [LUT_SIZE-1:0] tab_a;
    } cfg_t;

    function automatic logic shannon_pick(input logic sel_en, input logic sel,
                                          input logic low, input logic high);
        return (sel_en && sel) ? high : low;
    endfunction

endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic [DEPTH-1:0]  table_bits,
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_out
);
    // Binary mux tree: each level halves the candidate set using one address bit.
    logic [DEPTH-1:0] lvl [ADDR_W+1];

    assign lvl[0] = table_bits;

    for (genvar l = 0; l < ADDR_W; l++) begin : g_level
        localparam int unsigned N = DEPTH >> (l + 1);
        for (genvar k = 0; k < DEPTH; k++) begin : g_node
            if (k < N) begin : g_used
                assign lvl[l+1][k] = addr[l] ? lvl[l][2*k+1] : lvl[l][2*k];
            end else begin : g_pad
                assign lvl[l+1][k] = 1'b0;
            end
        end
    end

    assign bit_out = lvl[ADDR_W][0];

endmodule

// File: rtl/clb_ff.sv
module clb_ff (
    input  logic clk,
    input  logic rst,
    input  logic neg_edge,
    input  logic ce_en,
    input  logic sr_en,
    input  logic sr_val,
    input  logic ce,
    input  logic sr,
    input  logic d,
    output logic q
);
    logic edge_hit;
    logic load_en;

    // True on the configured edge: clk just rose and rising mode, or just fell and falling mode.
    assign edge_hit = (clk != neg_edge);
    assign load_en  = !ce_en || ce;

    always_ff @(posedge clk or negedge clk) begin
        if (edge_hit) begin
            if (rst)
                q <= 1'b0;
            else if (sr_en && sr)
                q <= sr_val;
            else if (load_en)
                q <= d;
        end
    end

    // Rising-mode checks, sampled on rising edges with the mode held on both sides.
    assert_sr_force_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !neg_edge && sr_en && sr) && !neg_edge) |-> (q == $past(sr_val)))
        else $error("set/reset did not force the stored value");

    assert_ce_hold_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && !neg_edge && ce_en && !ce && !(sr_en && sr)) && !neg_edge) |-> $stable(q))
        else $error("stored value changed with enable low");

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rst && !neg_edge) && !neg_edge) |-> (q == 1'b0))
        else $error("reset did not clear the stored value");

endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic [DIN_W-1:0]    din,
    input  logic                ce_in,
    input  logic                sr_in,
    output logic                q_out,
    output logic                c_out
);
    cfg_t              cfg;
    logic [LUT_SIZE-1:0] tabs [NUM_LUT];
    logic [NUM_LUT-1:0]  lut_bit;
    logic              func;
    logic              ff_q;

    assign cfg     = cfg_t'(cfg_word);
    assign tabs[0] = cfg.tab_a;
    assign tabs[1] = cfg.tab_b;

    for (genvar t = 0; t < NUM_LUT; t++) begin : g_lut
        clb_lut #(.ADDR_W(LUT_IN)) u_lut (
            .table_bits (tabs[t]),
            .addr       (din[LUT_IN-1:0]),
            .bit_out    (lut_bit[t])
        );
    end

    // Shannon expansion on the fourth input.
    assign func = shannon_pick(cfg.ctl.use_mux, din[LUT_IN], lut_bit[0], lut_bit[1]);

    clb_ff u_ff (
        .clk      (clk),
        .rst      (rst),
        .neg_edge (cfg.ctl.neg_edge),
        .ce_en    (cfg.ctl.ce_en),
        .sr_en    (cfg.ctl.sr_en),
        .sr_val   (cfg.ctl.sr_val),
        .ce       (ce_in),
        .sr       (sr_in),
        .d        (func),
        .q        (ff_q)
    );

    assign q_out = cfg.ctl.reg_out ? ff_q : func;
    assign c_out = lut_bit[0];

    assert_low_half_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ctl.reg_out && cfg.ctl.use_mux && !din[LUT_IN]) |-> (q_out == c_out))
        else $error("lower half of the function differs from table A");

    assert_no_mux_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.ctl.reg_out && !cfg.ctl.use_mux) |-> (q_out == c_out))
        else $error("combinational output differs from table A with mux off");

endmodule

// File: tb/sim_clb_cell.sv
`timescale 1ns/1ps
module sim_clb_cell;

    localparam int CLK_PERIOD = 10;
    localparam int CFG_W = 22;

    localparam logic [5:0] F_CE  = 6'b000001;
    localparam logic [5:0] F_SR  = 6'b000010;
    localparam logic [5:0] F_VAL = 6'b000100;
    localparam logic [5:0] F_MUX = 6'b001000;
    localparam logic [5:0] F_NEG = 6'b010000;
    localparam logic [5:0] F_REG = 6'b100000;

    // Vector: {cfg[21:0], din[3:0], expected q_out, expected c_out}
    localparam logic [27:0] VECS [6] = '{
        {6'b001000, 8'h01, 8'h80, 4'b0111, 1'b1, 1'b1},
        {6'b001000, 8'h01, 8'h80, 4'b1111, 1'b0, 1'b1},
        {6'b001000, 8'h01, 8'h80, 4'b1000, 1'b1, 1'b0},
        {6'b001000, 8'h01, 8'h80, 4'b0000, 1'b0, 1'b0},
        {6'b000000, 8'h01, 8'h80, 4'b1000, 1'b0, 1'b0},
        {6'b000000, 8'h01, 8'h80, 4'b1111, 1'b1, 1'b1}
    };

    localparam logic [15:0] PATS [4] = '{16'hA53C, 16'h0FF0, 16'h6996, 16'hC381};

    logic              clk = 1'b0;
    logic              rst;
    logic [CFG_W-1:0]  cfg_word;
    logic [3:0]        din;
    logic              ce_in;
    logic              sr_in;
    logic              q_out;
    logic              c_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    clb_cell u0 (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .din(din),
        .ce_in(ce_in), .sr_in(sr_in), .q_out(q_out), .c_out(c_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [CFG_W-1:0] mk(input logic [5:0] f, input logic [7:0] b,
                                            input logic [7:0] a);
        return {f, b, a};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Move to 1 ns after the next rising edge.
    task automatic adv();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_in = 1'b0; sr_in = 1'b0; din = 4'b0111;
        cfg_word = mk(F_REG, 8'h00, 8'h80);
        adv();
        adv();
        chk("R8 reset state", q_out, 1'b0);

        // Vector table walk: R1, R2, R3
        rst = 1'b0;
        foreach (VECS[i]) begin
            cfg_word = VECS[i][27:6];
            din      = VECS[i][5:2];
            #2;
            chk("R2/R3 vector q_out", q_out, VECS[i][1]);
            chk("R1 vector c_out", c_out, VECS[i][0]);
            adv();
        end

        // Full input sweep over fixed and pseudo-random table contents: R1, R2, R3
        for (int p = 0; p < 6; p++) begin
            logic [15:0] pat;
            pat = (p < 4) ? PATS[p] : 16'($urandom());
            for (int m = 0; m < 2; m++) begin
                for (int v = 0; v < 16; v++) begin
                    logic expq;
                    logic [2:0] ix;
                    ix = 3'(v);
                    cfg_word = mk((m == 1) ? F_MUX : 6'b0, pat[15:8], pat[7:0]);
                    din = 4'(v);
                    expq = (m == 1 && v >= 8) ? pat[8 + ix] : pat[ix];
                    #2;
                    chk("R1 sweep c_out", c_out, pat[ix]);
                    chk("R2 R3 sweep q_out", q_out, expq);
                    adv();
                end
            end
        end

        // R4 / R5 rising mode: table A = 0x80 so function is 1 only at din[2:0]=111
        cfg_word = mk(F_REG, 8'h00, 8'h80);
        din = 4'b0000;
        adv();
        chk("R4 load zero", q_out, 1'b0);
        din = 4'b0111;
        #7;
        chk("R5 falling edge ignored in rising mode", q_out, 1'b0);
        adv();
        chk("R4 registered load", q_out, 1'b1);

        // R5 falling mode
        cfg_word = mk(F_REG | F_NEG, 8'h00, 8'h80);
        din = 4'b0000;
        #7;
        chk("R5 falling edge loads", q_out, 1'b0);
        din = 4'b0111;
        adv();
        chk("R5 rising edge ignored in falling mode", q_out, 1'b0);
        #7;
        chk("R5 next falling edge loads", q_out, 1'b1);
        adv();

        // R6 clock enable
        cfg_word = mk(F_REG | F_CE, 8'h00, 8'h80);
        din = 4'b0000; ce_in = 1'b0;
        adv();
        chk("R6 hold with enable low", q_out, 1'b1);
        ce_in = 1'b1;
        adv();
        chk("R6 load with enable high", q_out, 1'b0);
        cfg_word = mk(F_REG, 8'h00, 8'h80);
        din = 4'b0111; ce_in = 1'b0;
        adv();
        chk("R6 enable ignored when flag clear", q_out, 1'b1);

        // R7 set/reset
        cfg_word = mk(F_REG | F_SR | F_CE, 8'h00, 8'h80);
        sr_in = 1'b1; ce_in = 1'b0; din = 4'b0111;
        adv();
        chk("R7 clear overrides enable", q_out, 1'b0);
        cfg_word = mk(F_REG | F_SR | F_VAL, 8'h00, 8'h80);
        din = 4'b0000;
        adv();
        chk("R7 set to one", q_out, 1'b1);
        cfg_word = mk(F_REG, 8'h00, 8'h80);
        adv();
        chk("R7 request ignored when flag clear", q_out, 1'b0);

        // R8 reset priority over set
        cfg_word = mk(F_REG | F_SR | F_VAL, 8'h00, 8'h80);
        din = 4'b0111;
        adv();
        chk("R7 set before reset test", q_out, 1'b1);
        rst = 1'b1;
        adv();
        chk("R8 reset beats set", q_out, 1'b0);
        rst = 1'b0; sr_in = 1'b0;
        adv();
        chk("R8 release then load", q_out, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule